// File: doc/BRIEF.md
# Power-Up Memory Self-Test and Repair Sequencer

This block wraps a small register-file memory that has a few spare rows. When reset is released, it runs a self-test before the memory can be used. The spare rows are tested first, then the main rows. Each row gets a write/read check with an all-zeros word and then an all-ones word. A spare row that fails is marked unusable for the rest of the session.

A main row that fails stops the sequence. The failing row address and the mask of bad bits go to a repair allocator, which binds that row to the lowest-numbered spare that is both healthy and still free. When the allocator answers, the sequence continues at the next row. If no spare is left, a sticky repair-failed flag is raised and the sequence ends at once.

After the sequence, the block serves ordinary single-word reads and writes. A wrapper sends each access to the main array or to the spare that replaced the row. Accesses are accepted only once the sequence has finished and only if repair has not failed. Cell defects are modelled by stuck-at-0 and stuck-at-1 mask parameters on the read path of each array.

Top module: `pwrup_mem_repair`

## Requirements
- R1: While reset is applied, and on the first clock edges after it, `done`, `repair_fail` and `acc_rvalid` are 0.
- R2: All spare rows (index 0 upward) are tested before any main row. No main row is tested until the last spare row has finished.
- R3: Each row is written with all-zeros and read back, then written with all-ones and read back, with two cycles per pattern. A bit that differs in either read counts as a fault, so stuck-at-0 and stuck-at-1 cells are both found.
- R4: A spare row that shows a fault is never allocated as a replacement.
- R5: A faulty main row pauses the sequence. The row address and failing-bit mask go to the allocator, and the sequence resumes at the next main row when the allocator answers. The whole sequence takes 4·(ROWS+SPARES) cycles plus 2 cycles per main-row fault. Counting the 2-cycle reset synchronizer, `done` is high after posedge 2+4·(ROWS+SPARES)+2·faults following reset release (50 for a clean default instance).
- R6: The allocator assigns the lowest-numbered spare that is healthy and unused.
- R7: A main-row fault with no healthy free spare sets `repair_fail`. The flag stays set, and the sequence ends with `done` high at the same point it would have paused.
- R8: `done` rises once, at the end of the sequence, and then stays high until reset.
- R9: An access is accepted only when `acc_en` is 1, `done` is 1, `repair_fail` is 0 and `acc_row` < ROWS. When an access is not accepted, a read gives no `acc_rvalid` and a write changes nothing.
- R10: In normal mode, an access to a repaired row goes to its spare, and every other row goes to the main array. Read data appears on `acc_rdata` with `acc_rvalid` one cycle after the accepted read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released through a 2-flop synchronizer |
| acc_en | input | 1 | Normal-mode access request |
| acc_we | input | 1 | 1 = write, 0 = read |
| acc_row | input | $clog2(ROWS) | Logical row address |
| acc_wdata | input | WIDTH | Write data |
| acc_rdata | output | WIDTH | Registered read data |
| acc_rvalid | output | 1 | Read data valid, one cycle after an accepted read |
| done | output | 1 | Self-test and repair sequence finished |
| repair_fail | output | 1 | Sticky: a main fault could not be repaired |

## Verification
Four instances with different defect maps are run side by side, and each has an exact expected finishing cycle. An allocator that searched from the top, or a sequence that tested main rows before spares, would bind a repaired row to a defective spare, and the bench would then read back corrupted data. Each main defect polarity is placed where only one of the two patterns can find it, so a bench that dropped the all-ones or the all-zeros pass would leave a row unrepaired and return a stuck bit. The instance whose spares run out must finish with the fail flag set and must refuse reads, while an early read on a healthy instance must stay unanswered until the cycle after done.

// File: rtl/pmr_pkg.sv
package pmr_pkg;

  typedef enum logic [2:0] {
    ST_WR0   = 3'd0,
    ST_RD0   = 3'd1,
    ST_WR1   = 3'd2,
    ST_RD1   = 3'd3,
    ST_PAUSE = 3'd4,
    ST_DONE  = 3'd5
  } seq_state_t;

endpackage

// File: rtl/pmr_storage.sv
module pmr_storage #(
  parameter int ROWS   = 10,
  parameter int WIDTH  = 10,
  parameter int SPARES = 2,
  parameter int AW     = 4,
  parameter int SW     = 1,
  parameter logic [ROWS*WIDTH-1:0]   MAIN_SA0  = '0,
  parameter logic [ROWS*WIDTH-1:0]   MAIN_SA1  = '0,
  parameter logic [SPARES*WIDTH-1:0] SPARE_SA0 = '0,
  parameter logic [SPARES*WIDTH-1:0] SPARE_SA1 = '0
) (
  input  logic             clk,
  input  logic             we,
  input  logic             use_spare,
  input  logic [AW-1:0]    row,
  input  logic [SW-1:0]    sidx,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] rdata
);

  logic [WIDTH-1:0] main_q    [ROWS];
  logic [WIDTH-1:0] spare_q   [SPARES];
  logic [WIDTH-1:0] main_view [ROWS];
  logic [WIDTH-1:0] spare_view[SPARES];

  // Row storage: register files without reset
  always_ff @(posedge clk) begin
    if (we && !use_spare && (row < AW'(ROWS))) begin
      main_q[row] <= wdata;
    end
    if (we && use_spare) begin
      spare_q[sidx] <= wdata;
    end
  end

  // Defect model on the read side of every row
  for (genvar g = 0; g < ROWS; g++) begin : g_main_view
    assign main_view[g] = (main_q[g] & ~MAIN_SA0[g*WIDTH +: WIDTH])
                        | MAIN_SA1[g*WIDTH +: WIDTH];
  end
  for (genvar s = 0; s < SPARES; s++) begin : g_spare_view
    assign spare_view[s] = (spare_q[s] & ~SPARE_SA0[s*WIDTH +: WIDTH])
                         | SPARE_SA1[s*WIDTH +: WIDTH];
  end

  always_comb begin
    rdata = '0;
    if (use_spare) begin
      rdata = spare_view[sidx];
    end else if (row < AW'(ROWS)) begin
      rdata = main_view[row];
    end
  end

endmodule

// File: rtl/pmr_alloc.sv
module pmr_alloc #(
  parameter int SPARES = 2,
  parameter int WIDTH  = 10,
  parameter int AW     = 4,
  parameter int SW     = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mark_bad,
  input  logic [SW-1:0]    bad_idx,
  input  logic             syn_valid,
  input  logic [AW-1:0]    syn_row,
  input  logic [WIDTH-1:0] syn_mask,
  input  logic [AW-1:0]    lookup_row,
  output logic             lookup_hit,
  output logic [SW-1:0]    lookup_idx,
  output logic             alloc_done,
  output logic             alloc_ok
);

  logic [SPARES-1:0] bad_q, bad_d;
  logic [SPARES-1:0] used_q, used_d;
  logic [AW-1:0]     map_q [SPARES];
  logic [AW-1:0]     map_d [SPARES];
  logic              done_q, done_d;
  logic              ok_q, ok_d;

  logic [SPARES-1:0] free_vec;
  logic [SW-1:0]     pick;
  logic              any_free;
  logic              accept;

  assign free_vec = ~bad_q & ~used_q;
  assign any_free = |free_vec;
  assign accept   = syn_valid && (|syn_mask) && !done_q;

  // Lowest-numbered healthy, unused spare
  always_comb begin
    pick = '0;
    for (int i = SPARES - 1; i >= 0; i--) begin
      if (free_vec[i]) pick = SW'(i);
    end
  end

  // Address translation for normal mode
  always_comb begin
    lookup_hit = 1'b0;
    lookup_idx = '0;
    for (int i = SPARES - 1; i >= 0; i--) begin
      if (used_q[i] && (map_q[i] == lookup_row)) begin
        lookup_hit = 1'b1;
        lookup_idx = SW'(i);
      end
    end
  end

  always_comb begin
    bad_d  = bad_q;
    used_d = used_q;
    map_d  = map_q;
    done_d = accept;
    ok_d   = ok_q;
    if (mark_bad) begin
      bad_d[bad_idx] = 1'b1;
    end
    if (accept) begin
      ok_d = any_free;
      if (any_free) begin
        used_d[pick] = 1'b1;
        map_d[pick]  = syn_row;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bad_q  <= '0;
      used_q <= '0;
      done_q <= 1'b0;
      ok_q   <= 1'b0;
      for (int i = 0; i < SPARES; i++) map_q[i] <= '0;
    end else begin
      bad_q  <= bad_d;
      used_q <= used_d;
      done_q <= done_d;
      ok_q   <= ok_d;
      map_q  <= map_d;
    end
  end

  assign alloc_done = done_q;
  assign alloc_ok   = ok_q;

endmodule

// File: rtl/pmr_bist_seq.sv
module pmr_bist_seq
  import pmr_pkg::*;
#(
  parameter int ROWS   = 10,
  parameter int WIDTH  = 10,
  parameter int SPARES = 2,
  parameter int AW     = 4,
  parameter int SW     = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] rdata,
  input  logic             alloc_done,
  input  logic             alloc_ok,
  output logic             t_we,
  output logic             t_use_spare,
  output logic [AW-1:0]    t_row,
  output logic [SW-1:0]    t_sidx,
  output logic [WIDTH-1:0] t_wdata,
  output logic             mark_bad,
  output logic             syn_valid,
  output logic [AW-1:0]    syn_row,
  output logic [WIDTH-1:0] syn_mask,
  output logic             in_main,
  output logic             done,
  output logic             repair_fail
);

  seq_state_t       state_q, state_d;
  logic [AW-1:0]    row_q, row_d;
  logic             main_q, main_d;
  logic [WIDTH-1:0] mask_q, mask_d;
  logic [AW-1:0]    srow_q, srow_d;
  logic [WIDTH-1:0] smask_q, smask_d;
  logic             fail_q, fail_d;

  logic [WIDTH-1:0] pattern;
  logic [WIDTH-1:0] diff;
  logic [WIDTH-1:0] row_mask;
  logic             last_row;
  seq_state_t       adv_state;
  logic [AW-1:0]    adv_row;
  logic             adv_main;

  assign pattern  = ((state_q == ST_WR1) || (state_q == ST_RD1)) ? '1 : '0;
  assign diff     = rdata ^ pattern;
  assign row_mask = mask_q | diff;
  assign last_row = main_q ? (row_q == AW'(ROWS - 1)) : (row_q == AW'(SPARES - 1));

  // Where the sequence goes after the current row
  always_comb begin
    adv_state = ST_WR0;
    adv_row   = row_q + AW'(1);
    adv_main  = main_q;
    if (last_row) begin
      adv_row = '0;
      if (main_q) begin
        adv_state = ST_DONE;
      end else begin
        adv_main = 1'b1;
      end
    end
  end

  always_comb begin
    state_d  = state_q;
    row_d    = row_q;
    main_d   = main_q;
    mask_d   = mask_q;
    srow_d   = srow_q;
    smask_d  = smask_q;
    fail_d   = fail_q;
    mark_bad = 1'b0;
    unique case (state_q)
      ST_WR0: state_d = ST_RD0;
      ST_RD0: begin
        mask_d  = diff;
        state_d = ST_WR1;
      end
      ST_WR1: state_d = ST_RD1;
      ST_RD1: begin
        if ((row_mask != '0) && main_q) begin
          srow_d  = row_q;
          smask_d = row_mask;
          state_d = ST_PAUSE;
        end else begin
          mark_bad = (row_mask != '0);
          state_d  = adv_state;
          row_d    = adv_row;
          main_d   = adv_main;
        end
      end
      ST_PAUSE: begin
        if (alloc_done) begin
          if (!alloc_ok) begin
            fail_d  = 1'b1;
            state_d = ST_DONE;
          end else begin
            state_d = adv_state;
            row_d   = adv_row;
            main_d  = adv_main;
          end
        end
      end
      ST_DONE: state_d = ST_DONE;
      default: state_d = ST_DONE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_WR0;
      row_q   <= '0;
      main_q  <= 1'b0;
      mask_q  <= '0;
      srow_q  <= '0;
      smask_q <= '0;
      fail_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      row_q   <= row_d;
      main_q  <= main_d;
      mask_q  <= mask_d;
      srow_q  <= srow_d;
      smask_q <= smask_d;
      fail_q  <= fail_d;
    end
  end

  assign t_we        = (state_q == ST_WR0) || (state_q == ST_WR1);
  assign t_use_spare = !main_q;
  assign t_row       = row_q;
  assign t_sidx      = row_q[SW-1:0];
  assign t_wdata     = pattern;
  assign syn_valid   = (state_q == ST_PAUSE);
  assign syn_row     = srow_q;
  assign syn_mask    = smask_q;
  assign in_main     = main_q;
  assign done        = (state_q == ST_DONE);
  assign repair_fail = fail_q;

endmodule

// File: rtl/pwrup_mem_repair.sv
module pwrup_mem_repair #(
  parameter int ROWS   = 10,
  parameter int WIDTH  = 10,
  parameter int SPARES = 2,
  parameter logic [ROWS*WIDTH-1:0]   MAIN_SA0  = '0,
  parameter logic [ROWS*WIDTH-1:0]   MAIN_SA1  = '0,
  parameter logic [SPARES*WIDTH-1:0] SPARE_SA0 = '0,
  parameter logic [SPARES*WIDTH-1:0] SPARE_SA1 = '0,
  localparam int AW = (ROWS > 1) ? $clog2(ROWS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc_en,
  input  logic             acc_we,
  input  logic [AW-1:0]    acc_row,
  input  logic [WIDTH-1:0] acc_wdata,
  output logic [WIDTH-1:0] acc_rdata,
  output logic             acc_rvalid,
  output logic             done,
  output logic             repair_fail
);

  localparam int SW = (SPARES > 1) ? $clog2(SPARES) : 1;

  // Reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_ns;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ns = rst_sync_q[1];

  logic             t_we, t_use_spare, mark_bad, syn_valid, in_main;
  logic [AW-1:0]    t_row, syn_row;
  logic [SW-1:0]    t_sidx, hit_idx;
  logic [WIDTH-1:0] t_wdata, syn_mask, sto_rdata;
  logic             alloc_done, alloc_ok, hit;

  pmr_bist_seq #(
    .ROWS(ROWS), .WIDTH(WIDTH), .SPARES(SPARES), .AW(AW), .SW(SW)
  ) u_seq (
    .clk         (clk),
    .rst_n       (rst_ns),
    .rdata       (sto_rdata),
    .alloc_done  (alloc_done),
    .alloc_ok    (alloc_ok),
    .t_we        (t_we),
    .t_use_spare (t_use_spare),
    .t_row       (t_row),
    .t_sidx      (t_sidx),
    .t_wdata     (t_wdata),
    .mark_bad    (mark_bad),
    .syn_valid   (syn_valid),
    .syn_row     (syn_row),
    .syn_mask    (syn_mask),
    .in_main     (in_main),
    .done        (done),
    .repair_fail (repair_fail)
  );

  pmr_alloc #(
    .SPARES(SPARES), .WIDTH(WIDTH), .AW(AW), .SW(SW)
  ) u_alloc (
    .clk        (clk),
    .rst_n      (rst_ns),
    .mark_bad   (mark_bad),
    .bad_idx    (t_sidx),
    .syn_valid  (syn_valid),
    .syn_row    (syn_row),
    .syn_mask   (syn_mask),
    .lookup_row (acc_row),
    .lookup_hit (hit),
    .lookup_idx (hit_idx),
    .alloc_done (alloc_done),
    .alloc_ok   (alloc_ok)
  );

  // Port steering: sequencer during test, remap wrapper afterwards
  logic             accept;
  logic             sto_we, sto_use_spare;
  logic [AW-1:0]    sto_row;
  logic [SW-1:0]    sto_sidx;
  logic [WIDTH-1:0] sto_wdata;

  assign accept        = acc_en && done && !repair_fail && (acc_row < AW'(ROWS));
  assign sto_we        = done ? (accept && acc_we) : t_we;
  assign sto_use_spare = done ? hit : t_use_spare;
  assign sto_row       = done ? acc_row : t_row;
  assign sto_sidx      = done ? hit_idx : t_sidx;
  assign sto_wdata     = done ? acc_wdata : t_wdata;

  pmr_storage #(
    .ROWS(ROWS), .WIDTH(WIDTH), .SPARES(SPARES), .AW(AW), .SW(SW),
    .MAIN_SA0(MAIN_SA0), .MAIN_SA1(MAIN_SA1),
    .SPARE_SA0(SPARE_SA0), .SPARE_SA1(SPARE_SA1)
  ) u_store (
    .clk       (clk),
    .we        (sto_we),
    .use_spare (sto_use_spare),
    .row       (sto_row),
    .sidx      (sto_sidx),
    .wdata     (sto_wdata),
    .rdata     (sto_rdata)
  );

  // Registered read return
  logic             rvalid_q, rvalid_d;
  logic [WIDTH-1:0] rdata_q;
  logic             rd_load;

  assign rd_load  = accept && !acc_we;
  assign rvalid_d = rd_load;

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      rvalid_q <= 1'b0;
      rdata_q  <= '0;
    end else begin
      rvalid_q <= rvalid_d;
      if (rd_load) rdata_q <= sto_rdata;
    end
  end

  assign acc_rvalid = rvalid_q;
  assign acc_rdata  = rdata_q;

endmodule

// File: rtl/pmr_checker.sv
module pmr_checker (
  input logic clk,
  input logic rst_n,
  input logic done,
  input logic repair_fail,
  input logic rvalid,
  input logic syn_valid,
  input logic alloc_done,
  input logic alloc_ok,
  input logic in_main,
  input logic mark_bad
);

  // R8: finished stays finished
  a_r8_done_holds: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> done);

  // R7: repair failure is sticky and ends the sequence
  a_r7_fail_holds: assert property (@(posedge clk) disable iff (!rst_n)
    repair_fail |=> repair_fail);
  a_r7_fail_ends_test: assert property (@(posedge clk) disable iff (!rst_n)
    repair_fail |-> done);
  a_r7_fail_from_reply: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(repair_fail) |-> $past(alloc_done && !alloc_ok));

  // R9: read data only after a clean finish
  a_r9_gated_reads: assert property (@(posedge clk) disable iff (!rst_n)
    rvalid |-> (done && !repair_fail));

  // R5: pause is held until the allocator answers, and answers follow requests
  a_r5_pause_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (syn_valid && !alloc_done) |=> syn_valid);
  a_r5_reply_after_request: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_done |-> $past(syn_valid));

  // R2: the main phase never returns to spares
  a_r2_main_after_spare: assert property (@(posedge clk) disable iff (!rst_n)
    in_main |=> in_main);

  // R4: spare rows are condemned only during the spare phase
  a_r4_mark_in_spare_phase: assert property (@(posedge clk) disable iff (!rst_n)
    mark_bad |-> !in_main);

endmodule

bind pwrup_mem_repair pmr_checker u_pmr_checker (
  .clk         (clk),
  .rst_n       (rst_ns),
  .done        (done),
  .repair_fail (repair_fail),
  .rvalid      (acc_rvalid),
  .syn_valid   (syn_valid),
  .alloc_done  (alloc_done),
  .alloc_ok    (alloc_ok),
  .in_main     (in_main),
  .mark_bad    (mark_bad)
);

// File: tb/tb_pwrup_mem_repair.sv
module tb_pwrup_mem_repair;

  localparam int CLK_PERIOD = 10;
  localparam int ROWS  = 10;
  localparam int WIDTH = 10;
  localparam int NDUT  = 4;

  logic clk;
  logic rst_n;
  logic             acc_en    [NDUT];
  logic             acc_we    [NDUT];
  logic [3:0]       acc_row   [NDUT];
  logic [WIDTH-1:0] acc_wdata [NDUT];
  logic [WIDTH-1:0] acc_rdata [NDUT];
  logic             acc_rvalid[NDUT];
  logic             done      [NDUT];
  logic             rfail     [NDUT];

  int checks;
  int errors;
  bit finished;

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // Instance 0: no defects
  pwrup_mem_repair dut (
    .clk(clk), .rst_n(rst_n), .acc_en(acc_en[0]), .acc_we(acc_we[0]),
    .acc_row(acc_row[0]), .acc_wdata(acc_wdata[0]), .acc_rdata(acc_rdata[0]),
    .acc_rvalid(acc_rvalid[0]), .done(done[0]), .repair_fail(rfail[0]));

  // Instance 1: spare 0 bit 2 stuck-1, main row 3 bit 5 stuck-0
  pwrup_mem_repair #(
    .SPARE_SA1(20'h00004),
    .MAIN_SA0(100'(1) << 35)
  ) dut_b (
    .clk(clk), .rst_n(rst_n), .acc_en(acc_en[1]), .acc_we(acc_we[1]),
    .acc_row(acc_row[1]), .acc_wdata(acc_wdata[1]), .acc_rdata(acc_rdata[1]),
    .acc_rvalid(acc_rvalid[1]), .done(done[1]), .repair_fail(rfail[1]));

  // Instance 2: three main rows stuck-1 (rows 1, 4, 8), only two spares
  pwrup_mem_repair #(
    .MAIN_SA1((100'(1) << 10) | (100'(1) << 49) | (100'(1) << 83))
  ) dut_c (
    .clk(clk), .rst_n(rst_n), .acc_en(acc_en[2]), .acc_we(acc_we[2]),
    .acc_row(acc_row[2]), .acc_wdata(acc_wdata[2]), .acc_rdata(acc_rdata[2]),
    .acc_rvalid(acc_rvalid[2]), .done(done[2]), .repair_fail(rfail[2]));

  // Instance 3: spare 1 bit 7 stuck-1, main row 6 bit 1 stuck-1
  pwrup_mem_repair #(
    .SPARE_SA1(20'h20000),
    .MAIN_SA1(100'(1) << 61)
  ) dut_d (
    .clk(clk), .rst_n(rst_n), .acc_en(acc_en[3]), .acc_we(acc_we[3]),
    .acc_row(acc_row[3]), .acc_wdata(acc_wdata[3]), .acc_rdata(acc_rdata[3]),
    .acc_rvalid(acc_rvalid[3]), .done(done[3]), .repair_fail(rfail[3]));

  task automatic check(input bit ok, input string req, input int got, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  task automatic do_write(input int d, input int row, input logic [WIDTH-1:0] data);
    @(negedge clk);
    acc_en[d] = 1'b1; acc_we[d] = 1'b1; acc_row[d] = 4'(row); acc_wdata[d] = data;
    @(negedge clk);
    acc_en[d] = 1'b0; acc_we[d] = 1'b0;
  endtask

  task automatic do_read(input int d, input int row, input logic [WIDTH-1:0] exp,
                         input string req);
    @(negedge clk);
    acc_en[d] = 1'b1; acc_we[d] = 1'b0; acc_row[d] = 4'(row);
    @(negedge clk);
    acc_en[d] = 1'b0;
    check(acc_rvalid[d] == 1'b1, req, int'(acc_rvalid[d]), 1);
    check(acc_rdata[d] == exp, req, int'(acc_rdata[d]), int'(exp));
  endtask

  // R1: outputs quiet in and just after reset
  task automatic t_reset_state();
    for (int d = 0; d < NDUT; d++) begin
      check(done[d] == 1'b0 && rfail[d] == 1'b0 && acc_rvalid[d] == 1'b0,
            "R1 reset state", int'({done[d], rfail[d], acc_rvalid[d]}), 0);
    end
  endtask

  // R2 R3 R5 R7 R8 R9: run the sequence while reads are held requested
  task automatic t_sequence();
    int first [NDUT];
    int exp_cyc [NDUT] = '{50, 52, 52, 52};
    bit exp_fail [NDUT] = '{1'b0, 1'b0, 1'b1, 1'b0};
    bit prev_done [NDUT];
    int early_valid [NDUT];
    int dropped [NDUT];
    for (int d = 0; d < NDUT; d++) begin
      first[d] = 0; prev_done[d] = 1'b0; early_valid[d] = 0; dropped[d] = 0;
      acc_en[d] = 1'b1; acc_we[d] = 1'b0; acc_row[d] = 4'd0;
    end
    for (int cyc = 1; cyc <= 120; cyc++) begin
      @(posedge clk);
      @(negedge clk);
      for (int d = 0; d < NDUT; d++) begin
        if (!prev_done[d] && acc_rvalid[d]) early_valid[d]++;
        if (prev_done[d] && !done[d]) dropped[d]++;
        if (done[d] && first[d] == 0) first[d] = cyc;
        prev_done[d] = done[d];
      end
    end
    for (int d = 0; d < NDUT; d++) acc_en[d] = 1'b0;
    for (int d = 0; d < NDUT; d++) begin
      check(first[d] == exp_cyc[d], "R5 R2 R3 finish cycle", first[d], exp_cyc[d]);
      check(rfail[d] == exp_fail[d], "R7 repair_fail", int'(rfail[d]), int'(exp_fail[d]));
      check(dropped[d] == 0, "R8 done held", dropped[d], 0);
      check(early_valid[d] == 0, "R9 no read before done", early_valid[d], 0);
    end
    // R9: failed instance never answered a read even after done
    check(acc_rvalid[2] == 1'b0, "R9 failed instance silent", int'(acc_rvalid[2]), 0);
  endtask

  // R10 R3: clean instance stores and returns data on every row
  task automatic t_clean_rw();
    for (int r = 0; r < ROWS; r++) do_write(0, r, WIDTH'(10'h2A5 ^ (r * 37)));
    for (int r = 0; r < ROWS; r++) do_read(0, r, WIDTH'(10'h2A5 ^ (r * 37)), "R10 clean row");
    do_write(0, 5, 10'h3FF);
    do_read(0, 5, 10'h3FF, "R3 all ones");
    do_write(0, 5, 10'h000);
    do_read(0, 5, 10'h000, "R3 all zeros");
  endtask

  // R4 R6 R10: repaired row uses spare 1 because spare 0 is defective
  task automatic t_spare_skip();
    do_write(1, 3, 10'h000);
    do_read(1, 3, 10'h000, "R4 R6 repaired row avoids bad spare");
    do_write(1, 3, 10'h3FF);
    do_read(1, 3, 10'h3FF, "R5 R10 stuck-0 row remapped");
    do_write(1, 2, 10'h155);
    do_read(1, 2, 10'h155, "R10 unrepaired row in main");
  endtask

  // R6: spare 1 defective, row 6 must land on spare 0
  task automatic t_lowest_spare();
    do_write(3, 6, 10'h000);
    do_read(3, 6, 10'h000, "R6 lowest healthy spare");
    do_write(3, 6, 10'h2AA);
    do_read(3, 6, 10'h2AA, "R6 R10 remapped data");
  endtask

  // R9: writes and reads on the failed instance have no effect
  task automatic t_failed_gate();
    do_write(2, 0, 10'h0F0);
    @(negedge clk);
    acc_en[2] = 1'b1; acc_we[2] = 1'b0; acc_row[2] = 4'd0;
    @(negedge clk);
    acc_en[2] = 1'b0;
    check(acc_rvalid[2] == 1'b0, "R9 read refused after fail", int'(acc_rvalid[2]), 0);
    check(done[2] == 1'b1 && rfail[2] == 1'b1, "R7 R8 flags still set",
          int'({done[2], rfail[2]}), 3);
  endtask

  initial begin
    checks = 0; errors = 0; finished = 1'b0;
    rst_n = 1'b0;
    for (int d = 0; d < NDUT; d++) begin
      acc_en[d] = 1'b0; acc_we[d] = 1'b0; acc_row[d] = '0; acc_wdata[d] = '0;
    end
    repeat (3) @(negedge clk);
    t_reset_state();
    rst_n = 1'b1;
    t_sequence();
    t_clean_rw();
    t_spare_skip();
    t_lowest_spare();
    t_failed_gate();
    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule